// File: doc/BRIEF.md
# Filtered Interrupt Combiner with Read-Time Status Capture

This block merges two active-low interrupt requests, one from each downstream channel, into a single active-low request for the upstream side. Each raw request is brought into the system clock domain by a two-stage synchronizer. It then passes a glitch filter that changes its settled level only after the new level has been held for a minimum number of clock cycles. The filter is asymmetric: going active takes longer than going idle, so short spikes are dropped and a brief release of an asserted line does not end the request.

The combined output is meant to drive the pull-low enable of an open-drain pad. It is low while at least one filtered channel is active. Beside it sits a status field that the bus controller reads. It is not live: it is loaded from the filtered levels only in a cycle where the controller signals a register read, and it holds that value until the next read. No channel-enable input exists, so detection and status never depend on which channels the switch currently routes.

Top module: `irq_combiner`

## Requirements
- R1: `irqOutN` is 0 while at least one filtered channel level is active (low), and 1 only while both are idle (high).
- R2: With the default filter widths, a raw level change that is held long enough shows up on `irqOutN` exactly LOW_MIN_CYCLES+2 rising edges later when asserting, and HIGH_MIN_CYCLES+2 rising edges later when releasing. The 2 extra edges come from the synchronizer. At 250 MHz with defaults 250/125 this is about 1.0 µs and 0.5 µs.
- R3: A raw low pulse held for fewer than LOW_MIN_CYCLES clock edges leaves the filtered level idle and `irqOutN` at 1. A pulse of exactly LOW_MIN_CYCLES edges is accepted.
- R4: While a channel is filtered active, a raw high pulse shorter than HIGH_MIN_CYCLES edges leaves the channel active and `irqOutN` at 0.
- R5: The two channels are filtered independently and may both be active together. Either channel alone keeps `irqOutN` at 0.
- R6: At a rising edge where `readStrobe` is 1, `statusReg` bit 4 loads 1 if channel 0 is filtered active and bit 5 loads 1 if channel 1 is filtered active. All other bits of `statusReg` read 0.
- R7: `statusReg` does not change at any edge where `readStrobe` is 0, even if the interrupt inputs change.
- R8: While `rst_n` is 0, both filtered levels are idle, `irqOutN` is 1 and `statusReg` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqReqN | input | 2 | Raw active-low interrupt requests; bit i belongs to channel i |
| readStrobe | input | 1 | One-cycle pulse from the bus controller when the status register is read |
| irqOutN | output | 1 | Combined active-low interrupt, used as the open-drain pull-low enable |
| statusReg | output | 8 | Status byte; bits 5 and 4 hold the channel 1 and channel 0 snapshot |

## Verification
The embedded properties assume both minimum widths are at least 2 cycles. They also assume that `readStrobe` is a plain synchronous pulse with no relation to the interrupt inputs. The raw requests may be fully asynchronous, since only the synchronized copies reach the filter logic. The stimulus changes the requests and the read pulse only on falling clock edges. It uses a short filter configuration, with glitch widths chosen just below, at, and above each threshold, so both the rejection and acceptance sides of the filter run under the properties.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned CH_COUNT = 2;

  // One strobe per channel per direction, raised for the single cycle in
  // which that channel's filtered level must flip.
  typedef struct packed {
    logic [CH_COUNT-1:0] goActive;
    logic [CH_COUNT-1:0] goIdle;
  } filtStrobe_t;
endpackage

// File: rtl/irqc_filter_ctrl.sv
module irqc_filter_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned LOW_MIN_CYCLES  = 250,
  parameter int unsigned HIGH_MIN_CYCLES = 125
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_COUNT-1:0] rawReqN,
  input  logic [CH_COUNT-1:0] levelN,
  output filtStrobe_t         strobe
);
  localparam int unsigned MAX_MIN = (LOW_MIN_CYCLES > HIGH_MIN_CYCLES) ?
                                    LOW_MIN_CYCLES : HIGH_MIN_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_MIN) + 1;
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_MIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_MIN_CYCLES - 1);

  logic [CH_COUNT-1:0] syncA;
  logic [CH_COUNT-1:0] syncB;
  logic [CH_COUNT-1:0] doneAct;
  logic [CH_COUNT-1:0] doneIdl;

  // Two-flop synchronizer, idle (high) out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= rawReqN;
      syncB <= syncA;
    end
  end

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    logic [CNT_W-1:0] holdCnt;
    logic [CNT_W-1:0] needLast;
    logic             differs;
    logic             reached;

    assign differs  = syncB[ch] != levelN[ch];
    // Currently idle -> moving active needs the long width.
    assign needLast = levelN[ch] ? LOW_LAST : HIGH_LAST;
    assign reached  = differs && (holdCnt == needLast);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 holdCnt <= '0;
      else if (!differs || reached) holdCnt <= '0;
      else                        holdCnt <= holdCnt + 1'b1;
    end

    assign doneAct[ch] = reached &&  levelN[ch];
    assign doneIdl[ch] = reached && !levelN[ch];

    // R3: the hold counter never runs past the longer width.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      holdCnt < CNT_W'(MAX_MIN));

    if (LOW_MIN_CYCLES > 1) begin : g_low_chk
      // R3: going active needs the synced line low in the cycle before too.
      a_r3_low_held: assert property (@(posedge clk) disable iff (!rst_n)
        doneAct[ch] |-> ($past(syncB[ch]) == 1'b0));
    end
    if (HIGH_MIN_CYCLES > 1) begin : g_high_chk
      // R4: going idle needs the synced line high in the cycle before too.
      a_r4_high_held: assert property (@(posedge clk) disable iff (!rst_n)
        doneIdl[ch] |-> ($past(syncB[ch]) == 1'b1));
    end
  end

  always_comb begin
    strobe.goActive = doneAct;
    strobe.goIdle   = doneIdl;
  end
endmodule

// File: rtl/irqc_level_dp.sv
module irqc_level_dp
  import irqc_pkg::*;
#(
  parameter int unsigned STATUS_LSB = 4,
  parameter int unsigned REG_W      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  filtStrobe_t         strobe,
  input  logic                readStrobe,
  output logic [CH_COUNT-1:0] levelN,
  output logic                irqOutN,
  output logic [REG_W-1:0]    statusReg
);
  logic [CH_COUNT-1:0] statSnap;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    levelN[ch] <= 1'b1;
      else if (strobe.goActive[ch])  levelN[ch] <= 1'b0;
      else if (strobe.goIdle[ch])    levelN[ch] <= 1'b1;
    end

    // R3: a filtered level moves only on a strobe from the filter control.
    a_r3_flip_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(levelN[ch]) |->
        $past(strobe.goActive[ch] || strobe.goIdle[ch]));
  end

  // Wired-AND of active-low levels.
  assign irqOutN = &levelN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          statSnap <= '0;
    else if (readStrobe) statSnap <= ~levelN;
  end

  assign statusReg = REG_W'(statSnap) << STATUS_LSB;

  // R1: any channel going active pulls the combined line low next cycle.
  a_r1_assert_next: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe.goActive) |=> !irqOutN);

  // R1: the combined line only rises after some channel went idle.
  a_r1_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOutN) |-> $past(|strobe.goIdle));

  // R7: no read, no change of the visible status.
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !readStrobe |=> $stable(statusReg));

  // R6: at most the channel bits can ever be set.
  a_r6_field_width: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(statusReg) <= CH_COUNT);
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int unsigned LOW_MIN_CYCLES  = 250,
  parameter int unsigned HIGH_MIN_CYCLES = 125,
  parameter int unsigned STATUS_LSB      = 4,
  parameter int unsigned REG_W           = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_COUNT-1:0] irqReqN,
  input  logic                readStrobe,
  output logic                irqOutN,
  output logic [REG_W-1:0]    statusReg
);
  filtStrobe_t         strobe;
  logic [CH_COUNT-1:0] levelN;

  irqc_filter_ctrl #(
    .LOW_MIN_CYCLES  (LOW_MIN_CYCLES),
    .HIGH_MIN_CYCLES (HIGH_MIN_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rawReqN (irqReqN),
    .levelN  (levelN),
    .strobe  (strobe)
  );

  irqc_level_dp #(
    .STATUS_LSB (STATUS_LSB),
    .REG_W      (REG_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .readStrobe (readStrobe),
    .levelN     (levelN),
    .irqOutN    (irqOutN),
    .statusReg  (statusReg)
  );
endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;
  localparam int LOW_W  = 8;
  localparam int HIGH_W = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] irqReqN;
  logic       readStrobe;
  logic       irqOutN;
  logic [7:0] statusReg;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_combiner #(
    .LOW_MIN_CYCLES  (LOW_W),
    .HIGH_MIN_CYCLES (HIGH_W)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irqReqN    (irqReqN),
    .readStrobe (readStrobe),
    .irqOutN    (irqOutN),
    .statusReg  (statusReg)
  );

  typedef struct packed {
    logic [1:0] req;
    logic [7:0] hold;
    logic       expOut;
    logic [7:0] expStat;
  } vec_t;

  // Status: bit4 = ch0 active, bit5 = ch1 active.
  localparam vec_t VECS [11] = '{
    '{2'b11, 8'd20, 1'b1, 8'h00},  // idle
    '{2'b10, 8'd20, 1'b0, 8'h10},  // ch0 active (R1)
    '{2'b00, 8'd20, 1'b0, 8'h30},  // both active (R5)
    '{2'b01, 8'd20, 1'b0, 8'h20},  // ch1 alone holds line (R5)
    '{2'b11, 8'd20, 1'b1, 8'h00},  // all idle
    '{2'b10, 8'd5,  1'b1, 8'h00},  // short low glitch begins (R3)
    '{2'b11, 8'd20, 1'b1, 8'h00},  // glitch rejected (R3)
    '{2'b01, 8'd20, 1'b0, 8'h20},  // ch1 active
    '{2'b11, 8'd2,  1'b0, 8'h20},  // short high glitch (R4)
    '{2'b01, 8'd20, 1'b0, 8'h20},  // still active (R4)
    '{2'b11, 8'd20, 1'b1, 8'h00}   // released
  };

  task automatic check(input bit ok, input string tag,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic doRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int k;
    bit sawLow;
    rst_n      = 1'b0;
    irqReqN    = 2'b11;
    readStrobe = 1'b0;
    repeat (3) @(negedge clk);
    check(irqOutN == 1'b1, "R8 reset out", irqOutN, 1);
    check(statusReg == 8'h00, "R8 reset status", statusReg, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk.
    for (int i = 0; i < 11; i++) begin
      irqReqN = VECS[i].req;
      repeat (int'(VECS[i].hold)) @(negedge clk);
      check(irqOutN == VECS[i].expOut, $sformatf("R1/R4/R5 out vec %0d", i),
            irqOutN, VECS[i].expOut);
      doRead();
      check(statusReg == VECS[i].expStat, $sformatf("R6 status vec %0d", i),
            statusReg, VECS[i].expStat);
    end

    // R2: assertion latency.
    irqReqN = 2'b10;
    k = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (k == 0 && irqOutN == 1'b0) k = n;
    end
    check(k == LOW_W + 2, "R2 assert latency", k, LOW_W + 2);
    // R2: release latency.
    irqReqN = 2'b11;
    k = 0;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (k == 0 && irqOutN == 1'b1) k = n;
    end
    check(k == HIGH_W + 2, "R2 release latency", k, HIGH_W + 2);

    // R3: one cycle under the low width is dropped.
    irqReqN = 2'b01;
    repeat (LOW_W - 1) @(negedge clk);
    irqReqN = 2'b11;
    sawLow = 0;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (irqOutN == 1'b0) sawLow = 1;
    end
    check(sawLow == 0, "R3 under-width pulse", sawLow, 0);
    // R3: exactly the low width is accepted.
    irqReqN = 2'b01;
    sawLow = 0;
    for (int n = 0; n < LOW_W; n++) begin
      @(negedge clk);
      if (irqOutN == 1'b0) sawLow = 1;
    end
    irqReqN = 2'b11;
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (irqOutN == 1'b0) sawLow = 1;
    end
    check(sawLow == 1, "R3 exact-width pulse", sawLow, 1);

    // R7: status frozen between reads.
    irqReqN = 2'b01;
    repeat (20) @(negedge clk);
    doRead();
    check(statusReg == 8'h20, "R6 capture ch1", statusReg, 8'h20);
    irqReqN = 2'b11;
    repeat (20) @(negedge clk);
    check(statusReg == 8'h20, "R7 hold without read", statusReg, 8'h20);
    doRead();
    check(statusReg == 8'h00, "R6 recapture idle", statusReg, 0);

    // R8: reset while both channels active.
    irqReqN = 2'b00;
    repeat (20) @(negedge clk);
    doRead();
    check(statusReg == 8'h30, "R5 both status", statusReg, 8'h30);
    rst_n = 1'b0;
    @(negedge clk);
    check(irqOutN == 1'b1, "R8 mid-run reset out", irqOutN, 1);
    check(statusReg == 8'h00, "R8 mid-run reset status", statusReg, 0);
    irqReqN = 2'b11;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(irqOutN == 1'b1, "R8 idle after reset", irqOutN, 1);

    finish();
  end
endmodule